// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block produces the serial clock timing for an I2C master. A 16-bit count value sets the length of one timing unit in input-clock cycles. A speed-mode field chooses how those units are split. In standard mode the low half of the bit period is one unit long. In the fast modes it is two units long. The high half is one unit in both cases. The bit rate is therefore the input clock divided by the count times 2 (standard) or times 3 (fast).

A byte-level sequencer holds `bit_req` high while it wants further bits. At the first cycle of every low phase the block pulses `chg_stb`, which marks the moment to change SDA. During the high phase it pulses `smp_stb` once, which marks the moment to sample SDA. A programmable settle delay, counted in input-clock cycles, sets how long the sample strobe waits after SCL is actually seen high.

When SCL has been released but still reads low, a slave is stretching the clock. While that lasts, the high-phase count and the settle delay are frozen. Both restart from the beginning once SCL reads high. Timing for the high-speed mode is not produced. That mode code is timed like the fast modes.

Top module: `i2c_bit_timer`

## Requirements
- R1: During and right after the synchronous active-high reset, `scl_low` is 0 and neither strobe is asserted.
- R2: The count N is `baud_reg[15:0]`, and `baud_reg[31:16]` has no effect. While N is 0, `bit_req` is ignored: SCL is never driven low and no strobe is produced.
- R3: The speed mode is `ctrl_reg[5:4]`. Code 0 (standard) gives a low phase of N cycles. Codes 1, 2 and 3 give a low phase of 2N cycles. All other bits of `ctrl_reg` have no effect.
- R4: Without stretching, the high phase lasts max(N, S+3) cycles, where S is the settle delay. This equals N whenever S+3 <= N.
- R5: `chg_stb` is a one-cycle pulse in the first cycle of each low phase. `scl_low` never rises without it.
- R6: The settle delay S is `setup_reg[31:16]`. `smp_stb` pulses exactly once per bit, in cycle S+2 (0-based) after the first cycle in which SCL reads high during the high phase.
- R7: A high phase begins with SCL released. While SCL reads low in that phase, the high-phase timing and the settle delay are held. Both restart when SCL reads high, so a stretch of H cycles lengthens the high phase by exactly H.
- R8: `bit_req` is sampled in idle and in the last cycle of a high phase. If it is high there, the next low phase follows with no gap. If it is low, the block idles with SCL released.
- R9: `chg_stb` and `smp_stb` are never asserted together. `smp_stb` occurs only while SCL is released and reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_reg | input | 32 | Count configuration; bits 15:0 are the count N |
| ctrl_reg | input | 32 | Control configuration; bits 5:4 select the speed mode |
| setup_reg | input | 32 | Settle configuration; bits 31:16 are the delay S |
| bit_req | input | 1 | Sequencer wants another bit |
| scl_in | input | 1 | Sampled SCL line level |
| scl_low | output | 1 | Drive SCL low when 1, release when 0 |
| chg_stb | output | 1 | One-cycle pulse: change SDA now |
| smp_stb | output | 1 | One-cycle pulse: sample SDA now |

## Verification
The bench goes after settle delays longer than the count. A design that ended the high phase on the count alone would cut that phase short and would sample at the wrong cycle, or not at all. Stretched high phases of several lengths expose a design that keeps counting while SCL is held low, because its high phase then comes out shorter than H plus the nominal length. A count whose low half is zero but whose upper half is not, together with random junk in the unused configuration bits, catches decoding of the wrong field. The fast-plus and high-speed mode codes catch a design that doubles the low phase only for code 1. Back-to-back bits followed by a dropped request catch an idle gap inserted between bits and a bit launched without a request.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
    localparam int REG_W     = 32;
    localparam int BAUD_W    = 16;
    localparam int SETUP_W   = 16;
    localparam int SETUP_LSB = 16;
    localparam int SPEED_LSB = 4;
    localparam int SPEED_W   = 2;
    localparam int SPAN_W    = BAUD_W + 1;

    typedef enum logic [SPEED_W-1:0] {
        SPD_STD   = 2'd0,
        SPD_FAST  = 2'd1,
        SPD_FPLUS = 2'd2,
        SPD_HIGH  = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [BAUD_W-1:0]  count;
        logic [SETUP_W-1:0] settle;
        speed_e             speed;
    } tcfg_t;

    // Low phase length in cycles: one unit for standard, two otherwise.
    function automatic logic [SPAN_W-1:0] low_span(logic [BAUD_W-1:0] n, speed_e sp);
        return (sp == SPD_STD) ? {1'b0, n} : {n, 1'b0};
    endfunction
endpackage

// File: rtl/i2c_bt_cfg_decode.sv
module i2c_bt_cfg_decode
    import i2c_bt_pkg::*;
(
    input  logic [REG_W-1:0] baud_reg,
    input  logic [REG_W-1:0] ctrl_reg,
    input  logic [REG_W-1:0] setup_reg,
    output tcfg_t            cfg
);
    always_comb begin
        cfg.count  = baud_reg[BAUD_W-1:0];
        cfg.settle = setup_reg[SETUP_LSB +: SETUP_W];
        cfg.speed  = speed_e'(ctrl_reg[SPEED_LSB +: SPEED_W]);
    end

    // Fields without a function in this block.
    logic unused_bits;
    assign unused_bits = ^{baud_reg[REG_W-1:BAUD_W],
                           ctrl_reg[REG_W-1:SPEED_LSB+SPEED_W],
                           ctrl_reg[SPEED_LSB-1:0],
                           setup_reg[SETUP_LSB-1:0]};
endmodule

// File: rtl/i2c_bt_settle_timer.sv
module i2c_bt_settle_timer
    import i2c_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               restart,
    input  logic               run,
    input  logic [SETUP_W-1:0] load_val,
    output logic               expired
);
    localparam logic [SETUP_W-1:0] ONE = SETUP_W'(1);

    logic [SETUP_W-1:0] cnt;
    logic               armed;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            cnt   <= load_val;
            armed <= 1'b1;
        end else if (run && armed && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = armed && run && !restart && (cnt == '0);
endmodule

// File: rtl/i2c_bt_phase_ctrl.sv
module i2c_bt_phase_ctrl
    import i2c_bt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tcfg_t cfg,
    input  logic  bit_req,
    input  logic  scl_in,
    input  logic  tmr_expired,
    output logic  tmr_clear,
    output logic  tmr_restart,
    output logic  tmr_run,
    output logic  scl_low,
    output logic  chg_stb,
    output logic  smp_stb
);
    localparam logic [SPAN_W-1:0] ONE = SPAN_W'(1);

    phase_e            state;
    logic [SPAN_W-1:0] cnt;
    logic [BAUD_W-1:0] n_q;
    logic              seen_high;
    logic              sampled;
    logic              chg_q;
    logic              smp_q;

    logic              start_bit;
    logic              in_high;
    logic              take_sample;
    logic              high_end;
    logic [SPAN_W-1:0] launch_cnt;
    logic [SPAN_W-1:0] reload_cnt;

    always_comb begin
        start_bit   = bit_req && (cfg.count != '0);
        in_high     = (state == PH_HIGH);
        take_sample = in_high && scl_in && seen_high && tmr_expired && !sampled;
        high_end    = in_high && scl_in && (cnt == '0) && sampled;
        launch_cnt  = low_span(cfg.count, cfg.speed) - ONE;
        reload_cnt  = {1'b0, n_q} - ONE;
        tmr_clear   = !in_high;
        tmr_run     = in_high && scl_in;
        tmr_restart = in_high && scl_in && !seen_high;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            cnt       <= '0;
            n_q       <= '0;
            seen_high <= 1'b0;
            sampled   <= 1'b0;
            chg_q     <= 1'b0;
            smp_q     <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            smp_q <= take_sample;
            case (state)
                PH_IDLE: begin
                    if (start_bit) begin
                        state <= PH_LOW;
                        n_q   <= cfg.count;
                        cnt   <= launch_cnt;
                        chg_q <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        state     <= PH_HIGH;
                        cnt       <= reload_cnt;
                        seen_high <= 1'b0;
                        sampled   <= 1'b0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in) begin
                        cnt       <= reload_cnt;
                        seen_high <= 1'b0;
                    end else begin
                        seen_high <= 1'b1;
                        if (take_sample) sampled <= 1'b1;
                        if (high_end) begin
                            if (start_bit) begin
                                state <= PH_LOW;
                                n_q   <= cfg.count;
                                cnt   <= launch_cnt;
                                chg_q <= 1'b1;
                            end else begin
                                state <= PH_IDLE;
                            end
                        end else if (cnt != '0) begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign scl_low = (state == PH_LOW);
    assign chg_stb = chg_q;
    assign smp_stb = smp_q;
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] baud_reg,
    input  logic [REG_W-1:0] ctrl_reg,
    input  logic [REG_W-1:0] setup_reg,
    input  logic             bit_req,
    input  logic             scl_in,
    output logic             scl_low,
    output logic             chg_stb,
    output logic             smp_stb
);
    tcfg_t cfg;
    logic  tmr_clear;
    logic  tmr_restart;
    logic  tmr_run;
    logic  tmr_expired;

    i2c_bt_cfg_decode u_decode (
        .baud_reg  (baud_reg),
        .ctrl_reg  (ctrl_reg),
        .setup_reg (setup_reg),
        .cfg       (cfg)
    );

    i2c_bt_settle_timer u_settle (
        .clk      (clk),
        .rst      (rst),
        .clear    (tmr_clear),
        .restart  (tmr_restart),
        .run      (tmr_run),
        .load_val (cfg.settle),
        .expired  (tmr_expired)
    );

    i2c_bt_phase_ctrl u_phase (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .bit_req     (bit_req),
        .scl_in      (scl_in),
        .tmr_expired (tmr_expired),
        .tmr_clear   (tmr_clear),
        .tmr_restart (tmr_restart),
        .tmr_run     (tmr_run),
        .scl_low     (scl_low),
        .chg_stb     (chg_stb),
        .smp_stb     (smp_stb)
    );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] baud_reg,
    input logic             scl_in,
    input logic             scl_low,
    input logic             chg_stb,
    input logic             smp_stb
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(chg_stb && smp_stb));

    // R5
    chg_in_low_chk: assert property (@(posedge clk) disable iff (rst)
        chg_stb |-> scl_low);

    // R5
    low_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> chg_stb);

    // R9
    smp_high_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> (!scl_low && scl_in));

    // R6
    smp_single_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> !smp_stb);

    // R2
    zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (baud_reg[BAUD_W-1:0] == '0 && !scl_low) |=> !scl_low);
endmodule

bind i2c_bit_timer i2c_bit_timer_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .baud_reg (baud_reg),
    .scl_in   (scl_in),
    .scl_low  (scl_low),
    .chg_stb  (chg_stb),
    .smp_stb  (smp_stb)
);

// File: tb/i2c_bit_timer_tb_top.sv
module i2c_bit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] baud_reg = '0;
    logic [31:0] ctrl_reg = '0;
    logic [31:0] setup_reg = '0;
    logic        bit_req = 1'b0;
    logic        scl_in;
    logic        scl_low;
    logic        chg_stb;
    logic        smp_stb;

    int checks = 0;
    int errors = 0;
    int hold_cfg = 0;
    int hold_left = 0;

    always #10 clk = ~clk;

    // Slave model: keeps SCL low for hold_cfg cycles after the master releases it.
    always @(posedge clk) begin
        if (rst)               hold_left <= 0;
        else if (scl_low)      hold_left <= hold_cfg;
        else if (hold_left > 0) hold_left <= hold_left - 1;
    end
    assign scl_in = !scl_low && (hold_left == 0);

    i2c_bit_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .baud_reg  (baud_reg),
        .ctrl_reg  (ctrl_reg),
        .setup_reg (setup_reg),
        .bit_req   (bit_req),
        .scl_in    (scl_in),
        .scl_low   (scl_low),
        .chg_stb   (chg_stb),
        .smp_stb   (smp_stb)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Two bits back to back, then the request drops.
    task automatic run_case(input logic [31:0] b, input logic [31:0] c,
                            input logic [31:0] s, input int h);
        int n        = int'(b[15:0]);
        int sv       = int'(s[31:16]);
        int exp_low  = (c[5:4] != 2'd0) ? 2 * n : n;
        int exp_high = h + imax(n, sv + 3);
        int exp_smp  = h + sv + 2;
        int guard    = 0;
        int lc       = 0;
        int hc       = 0;
        int sp       = -1;
        int sc       = 0;
        int bad      = 0;
        int relaunch = 0;
        @(negedge clk);
        baud_reg  = b;
        ctrl_reg  = c;
        setup_reg = s;
        hold_cfg  = h;
        bit_req   = 1'b1;
        while (!chg_stb && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check(chg_stb && scl_low, "R5 change strobe opens the low phase", int'(chg_stb), 1);
        while (scl_low && lc < 100000) begin
            if (smp_stb) bad++;
            lc++;
            @(negedge clk);
        end
        check(lc == exp_low, "R3 low phase length", lc, exp_low);
        while (!chg_stb && hc < 100000) begin
            if (smp_stb) begin
                sc++;
                sp = hc;
                if (scl_low || !scl_in) bad++;
            end
            hc++;
            @(negedge clk);
        end
        bit_req = 1'b0;
        check(hc == exp_high, "R4 R7 R8 high phase length up to next bit", hc, exp_high);
        check(sc == 1, "R6 one sample strobe per bit", sc, 1);
        check(sp == exp_smp, "R6 sample strobe position", sp, exp_smp);
        check(bad == 0, "R9 sample strobe only with SCL high", bad, 0);
        guard = 0;
        while (scl_low && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        for (int i = 0; i < exp_high + 12; i++) begin
            @(negedge clk);
            if (scl_low || chg_stb) relaunch++;
        end
        check(relaunch == 0, "R8 idle once the request drops", relaunch, 0);
        hold_cfg = 0;
    endtask

    initial begin
        int unused_seed;
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        int quiet;
        unused_seed = $urandom(32'd20240611);
        bit_req = 1'b1;
        repeat (3) @(negedge clk);
        check(!scl_low && !chg_stb && !smp_stb, "R1 outputs quiet in reset",
              int'({scl_low, chg_stb, smp_stb}), 0);
        rst = 1'b0;
        bit_req = 1'b0;
        @(negedge clk);
        check(!scl_low && !chg_stb && !smp_stb, "R1 outputs quiet after reset",
              int'({scl_low, chg_stb, smp_stb}), 0);

        // R2: a count whose low half is zero disables the generator.
        baud_reg = 32'hFFFF_0000;
        bit_req  = 1'b1;
        quiet    = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (scl_low || chg_stb || smp_stb) quiet++;
        end
        check(quiet == 0, "R2 zero count ignores requests", quiet, 0);
        bit_req = 1'b0;
        @(negedge clk);

        // Directed corner cases.
        run_case(32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 0); // R4 standard, plain
        run_case(32'hABCD_0005, 32'hFFFF_FFCF, 32'h0000_FFFF, 0); // R2 R3 junk in unused bits
        run_case(32'h0000_0003, 32'h0000_0010, 32'h000E_0000, 0); // R4 settle longer than count
        run_case(32'h0000_0002, 32'h0000_0020, 32'h0000_0000, 0); // R3 fast-plus code
        run_case(32'h0000_0002, 32'h0000_0030, 32'h0000_0000, 0); // R3 high-speed code
        run_case(32'h0000_0004, 32'h0000_0000, 32'h0001_0000, 6); // R7 stretched high phase
        run_case(32'h0000_0001, 32'h0000_0010, 32'h0000_0000, 3); // R7 minimum count, stretched
        run_case(32'h0000_0008, 32'h0000_0010, 32'h0002_0000, 1); // R6 settle inside high phase

        // Constrained random mix.
        for (int k = 0; k < 30; k++) begin
            logic [31:0] b;
            logic [31:0] c;
            logic [31:0] s;
            int h;
            b = {$urandom() % 65536, 16'd0} | (1 + ($urandom() % 12));
            c = $urandom();
            c[5:4] = 2'($urandom() % 4);
            s = {16'($urandom() % 16), 16'($urandom() % 65536)};
            h = $urandom() % 5;
            run_case(b, c, s, h);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule